// File: doc/BRIEF.md
# Mixed-Scheme Segmented Binary Adder

This block adds two unsigned operands and a carry-in in one combinational pass. The operand is cut into four contiguous slices, and each slice resolves its carries in a different way. The least significant slice uses a plain full-adder chain. The next slice lets the carry jump over fully propagating 4-bit groups. The third slice precomputes both possible results and picks one with a multiplexer. The most significant slice forms its carries in 4-bit lookahead groups. The carry leaving each slice is the carry entering the next one.

Every slice width is a parameter, and a slice can be left out by setting its width to 0. This lets an integrator move the design between small area and short carry path without changing the port list. A slice of width 0 passes its carry straight through. Elaboration stops with a fatal error if the four widths do not add up to the total width. There is no clock and no reset inside the block.

Top module: `hetero_adder`

## Requirements
- R1: With the default widths (4/4/4/4, 16 bits total), `{carry_out, sum}` equals `op_a + op_b + carry_in` as a 17-bit value for every input.
- R2: When both operands are zero, `sum` equals `carry_in` (bit 0 only) and `carry_out` is 0.
- R3: When `op_a ^ op_b` is all ones, a carry-in of 1 gives `sum` = 0 with `carry_out` = 1, and a carry-in of 0 gives `sum` all ones with `carry_out` = 0.
- R4: The carry into each slice equals the carry that exact addition of the lower bits produces. A carry generated at the top bit of any slice therefore appears at the lowest bit of the next slice. For example, `op_a` = 2^k - 1 and `op_b` = 1 give `sum` = 2^k.
- R5: With widths 8/0/4/4 (the skip slice left out), the 17-bit result still equals `op_a + op_b + carry_in`.
- R6: With widths 5/4/4/3, the 17-bit result equals `op_a + op_b + carry_in`.
- R7: With widths 0/7/0/9, where the skip and lookahead slices end in partial groups of 3 and 1 bits, the 17-bit result equals `op_a + op_b + carry_in`.
- R8: With widths 0/0/16/0, where the whole word is one select slice and the other three slices pass their carry through, the 17-bit result equals `op_a + op_b + carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | DATA_W (16) | First operand |
| op_b | input | DATA_W (16) | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | DATA_W (16) | Low DATA_W bits of the result |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The bound checker evaluates every input change in every instantiated configuration. It checks the exact 17-bit sum, the zero-operand case and the full-propagate case. It also checks the carry at each slice boundary against the carry of the lower bits, which catches a broken hand-off or a faulty pass-through even when the final sum happens to be right. Only the bench's scenarios can show that each slice ordering and partial-group arrangement is actually exercised: distinct configurations, boundary-targeted carry chains, and exhaustive low-nibble sweeps with random upper bits.

// File: rtl/hetero_adder_pkg.sv
// Package: shared types and carry helpers for the segmented adder.
// Assumes callers pass lookahead group vectors of at most 4 bits.
package hetero_adder_pkg;

    localparam int SKIP_GRP = 4;
    localparam int LA_GRP   = 4;

    typedef struct packed {
        logic s;
        logic co;
    } fa_t;

    // One-bit full adder.
    function automatic fa_t full_add(logic x, logic y, logic ci);
        fa_t r;
        r.s  = x ^ y ^ ci;
        r.co = (x & y) | (ci & (x ^ y));
        return r;
    endfunction

    // Sum-of-products carry into bit n of a 4-bit group.
    function automatic logic la_carry(logic [3:0] gen, logic [3:0] prop,
                                      logic ci, int n);
        logic acc;
        logic term;
        acc = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (k < n) begin
                term = gen[k];
                for (int m = 0; m < 4; m++) begin
                    if (m > k && m < n) term = term & prop[m];
                end
                acc = acc | term;
            end
        end
        term = ci;
        for (int m = 0; m < 4; m++) begin
            if (m < n) term = term & prop[m];
        end
        return acc | term;
    endfunction

endpackage

// File: rtl/seg_ripple.sv
// Ripple slice: one full adder per bit, carries chained upward.
// Assumes W >= 1.
module seg_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    import hetero_adder_pkg::*;

    logic [W:0] c;

    assign c[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        fa_t r;
        // Bit i of the slice: sum and carry to bit i+1.
        assign r        = full_add(a[i], b[i], c[i]);
        assign s[i]     = r.s;
        assign c[i+1]   = r.co;
    end

    assign co = c[W];
endmodule

// File: rtl/seg_skip.sv
// Skip slice: ripple inside each group; a fully propagating group
// hands its carry-in straight to the next group. Assumes W >= 1.
module seg_skip #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    import hetero_adder_pkg::*;

    localparam int NG = (W + SKIP_GRP - 1) / SKIP_GRP;

    logic [NG:0] gc;

    assign gc[0] = ci;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LO = g * SKIP_GRP;
        localparam int GW = ((W - LO) < SKIP_GRP) ? (W - LO) : SKIP_GRP;
        logic rip_co;
        logic bypass;

        seg_ripple #(.W(GW)) u_rip (
            .a  (a[LO +: GW]),
            .b  (b[LO +: GW]),
            .ci (gc[g]),
            .s  (s[LO +: GW]),
            .co (rip_co)
        );

        // Group skips when every bit propagates.
        assign bypass  = &(a[LO +: GW] ^ b[LO +: GW]);
        // Group carry-out: bypassed carry-in or rippled carry.
        assign gc[g+1] = bypass ? gc[g] : rip_co;
    end

    assign co = gc[NG];
endmodule

// File: rtl/seg_select.sv
// Select slice: two speculative ripple sums (carry 0 and carry 1),
// real carry-in picks one. Assumes W >= 1.
module seg_select #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] s0;
    logic [W-1:0] s1;
    logic         c0;
    logic         c1;

    seg_ripple #(.W(W)) u_zero (
        .a  (a),
        .b  (b),
        .ci (1'b0),
        .s  (s0),
        .co (c0)
    );

    seg_ripple #(.W(W)) u_one (
        .a  (a),
        .b  (b),
        .ci (1'b1),
        .s  (s1),
        .co (c1)
    );

    // Final multiplexer driven by the incoming carry.
    assign s  = ci ? s1 : s0;
    assign co = ci ? c1 : c0;
endmodule

// File: rtl/seg_lookahead.sv
// Lookahead slice: per-bit propagate (XOR) and generate (AND); carries
// formed as sum-of-products inside 4-bit groups, groups chained by
// group generate/propagate. Assumes W >= 1.
module seg_lookahead #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    import hetero_adder_pkg::*;

    localparam int NG = (W + LA_GRP - 1) / LA_GRP;

    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic [NG:0]  gc;

    assign prop  = a ^ b;
    assign gen   = a & b;
    assign gc[0] = ci;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LO = g * LA_GRP;
        localparam int GW = ((W - LO) < LA_GRP) ? (W - LO) : LA_GRP;
        logic [3:0] pv;
        logic [3:0] gv;
        logic       grp_g;
        logic       grp_p;

        assign pv = 4'(prop[LO +: GW]);
        assign gv = 4'(gen[LO +: GW]);

        for (genvar j = 0; j < GW; j++) begin : g_bit
            // Sum bit j: propagate XOR lookahead carry.
            assign s[LO+j] = pv[j] ^ la_carry(gv, pv, gc[g], j);
        end

        // Group generate and propagate, then group carry-out.
        assign grp_g   = la_carry(gv, pv, 1'b0, GW);
        assign grp_p   = &pv[GW-1:0];
        assign gc[g+1] = grp_g | (grp_p & gc[g]);
    end

    assign co = gc[NG];
endmodule

// File: rtl/hetero_adder.sv
// Top: four slices from low to high (ripple, skip, select, lookahead),
// carries chained. A zero-width slice passes its carry through.
// Assumes the four widths sum to DATA_W; otherwise elaboration fails.
module hetero_adder #(
    parameter int DATA_W = 16,
    parameter int W_RC   = 4,
    parameter int W_SK   = 4,
    parameter int W_SL   = 4,
    parameter int W_LA   = 4
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum,
    output logic              carry_out
);
    localparam int O_RC = 0;
    localparam int O_SK = O_RC + W_RC;
    localparam int O_SL = O_SK + W_SK;
    localparam int O_LA = O_SL + W_SL;

    if (W_RC < 0 || W_SK < 0 || W_SL < 0 || W_LA < 0
        || (W_RC + W_SK + W_SL + W_LA) != DATA_W) begin : g_bad_widths
        $fatal(1, "hetero_adder: slice widths %0d/%0d/%0d/%0d do not sum to %0d",
               W_RC, W_SK, W_SL, W_LA, DATA_W);
    end

    // c_seg[k] is the carry into slice k; c_seg[4] leaves the block.
    logic [4:0] c_seg;

    assign c_seg[0] = carry_in;

    if (W_RC > 0) begin : g_rc
        seg_ripple #(.W(W_RC)) u_seg (
            .a  (op_a[O_RC +: W_RC]),
            .b  (op_b[O_RC +: W_RC]),
            .ci (c_seg[0]),
            .s  (sum[O_RC +: W_RC]),
            .co (c_seg[1])
        );
    end else begin : g_rc_pass
        assign c_seg[1] = c_seg[0];
    end

    if (W_SK > 0) begin : g_sk
        seg_skip #(.W(W_SK)) u_seg (
            .a  (op_a[O_SK +: W_SK]),
            .b  (op_b[O_SK +: W_SK]),
            .ci (c_seg[1]),
            .s  (sum[O_SK +: W_SK]),
            .co (c_seg[2])
        );
    end else begin : g_sk_pass
        assign c_seg[2] = c_seg[1];
    end

    if (W_SL > 0) begin : g_sl
        seg_select #(.W(W_SL)) u_seg (
            .a  (op_a[O_SL +: W_SL]),
            .b  (op_b[O_SL +: W_SL]),
            .ci (c_seg[2]),
            .s  (sum[O_SL +: W_SL]),
            .co (c_seg[3])
        );
    end else begin : g_sl_pass
        assign c_seg[3] = c_seg[2];
    end

    if (W_LA > 0) begin : g_la
        seg_lookahead #(.W(W_LA)) u_seg (
            .a  (op_a[O_LA +: W_LA]),
            .b  (op_b[O_LA +: W_LA]),
            .ci (c_seg[3]),
            .s  (sum[O_LA +: W_LA]),
            .co (c_seg[4])
        );
    end else begin : g_la_pass
        assign c_seg[4] = c_seg[3];
    end

    assign carry_out = c_seg[4];
endmodule

// File: rtl/hetero_adder_chk.sv
// Checker: immediate assertions on the combinational result and on the
// slice-boundary carries; bound into every hetero_adder instance.
module hetero_adder_chk #(
    parameter int DATA_W = 16,
    parameter int W_RC   = 4,
    parameter int W_SK   = 4,
    parameter int W_SL   = 4,
    parameter int W_LA   = 4
) (
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              carry_in,
    input logic [DATA_W-1:0] sum,
    input logic              carry_out,
    input logic [4:0]        seg_c
);
    logic [DATA_W:0] ref_full;
    logic [DATA_W:0] low_sum;
    logic [DATA_W:0] mask;
    int              bnd [5];

    assign ref_full = {1'b0, op_a} + {1'b0, op_b} + (DATA_W+1)'(carry_in);

    // Result checks on every input change.
    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            a_r1_exact_sum: assert ({carry_out, sum} == ref_full)
                else $error("R1: result mismatch");
            if (op_a == '0 && op_b == '0) begin
                a_r2_cin_only: assert (sum == DATA_W'(carry_in) && !carry_out)
                    else $error("R2: zero operands");
            end
            if ((op_a ^ op_b) == '1) begin
                a_r3_all_prop: assert (carry_out == carry_in
                                       && sum == (carry_in ? '0 : '1))
                    else $error("R3: full propagate");
            end
        end
    end

    // Boundary carry checks: carry into slice k vs exact low-bit carry.
    always_comb begin
        bnd[0] = 0;
        bnd[1] = W_RC;
        bnd[2] = W_RC + W_SK;
        bnd[3] = W_RC + W_SK + W_SL;
        bnd[4] = DATA_W;
        low_sum = '0;
        mask    = '0;
        if (!$isunknown({op_a, op_b, carry_in})) begin
            for (int k = 0; k < 5; k++) begin
                mask    = ((DATA_W+1)'(1) << bnd[k]) - (DATA_W+1)'(1);
                low_sum = ({1'b0, op_a} & mask) + ({1'b0, op_b} & mask)
                          + (DATA_W+1)'(carry_in);
                a_r4_seg_carry: assert (seg_c[k] == low_sum[bnd[k]])
                    else $error("R4: boundary carry %0d wrong", k);
            end
        end
    end
endmodule

bind hetero_adder hetero_adder_chk #(
    .DATA_W (DATA_W),
    .W_RC   (W_RC),
    .W_SK   (W_SK),
    .W_SL   (W_SL),
    .W_LA   (W_LA)
) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .seg_c     (c_seg)
);

// File: tb/tb_hetero_adder.sv
// Bench: five configurations driven in parallel with directed corners,
// exhaustive low-nibble sweeps and seeded random vectors.
module tb_hetero_adder;
    localparam int DW = 16;

    logic          clk;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic          ci;
    logic [DW-1:0] s_d, s_b, s_c, s_e, s_f;
    logic          co_d, co_b, co_c, co_e, co_f;
    int            n_run;
    int            n_fail;
    bit            done;

    initial clk = 1'b0;
    always #5 clk = ~clk;

    hetero_adder dut (
        .op_a(a), .op_b(b), .carry_in(ci), .sum(s_d), .carry_out(co_d));
    hetero_adder #(.W_RC(8), .W_SK(0), .W_SL(4), .W_LA(4)) dut_b (
        .op_a(a), .op_b(b), .carry_in(ci), .sum(s_b), .carry_out(co_b));
    hetero_adder #(.W_RC(5), .W_SK(4), .W_SL(4), .W_LA(3)) dut_c (
        .op_a(a), .op_b(b), .carry_in(ci), .sum(s_c), .carry_out(co_c));
    hetero_adder #(.W_RC(0), .W_SK(7), .W_SL(0), .W_LA(9)) dut_e (
        .op_a(a), .op_b(b), .carry_in(ci), .sum(s_e), .carry_out(co_e));
    hetero_adder #(.W_RC(0), .W_SK(0), .W_SL(16), .W_LA(0)) dut_f (
        .op_a(a), .op_b(b), .carry_in(ci), .sum(s_f), .carry_out(co_f));

    function automatic logic [DW:0] ref_add(logic [DW-1:0] x, logic [DW-1:0] y,
                                            logic c);
        return {1'b0, x} + {1'b0, y} + (DW+1)'(c);
    endfunction

    task automatic check(string req, logic [DW:0] got, logic [DW:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (a=%h b=%h ci=%b)",
                     req, got, exp, a, b, ci);
        end
    endtask

    // Drive on a rising edge, sample at the following falling edge.
    task automatic apply(logic [DW-1:0] x, logic [DW-1:0] y, logic c);
        @(posedge clk);
        a  = x;
        b  = y;
        ci = c;
        @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic [DW:0] e;
        e = ref_add(a, b, ci);
        check({"R1 ", tag}, {co_d, s_d}, e);
        check({"R5 ", tag}, {co_b, s_b}, e);
        check({"R6 ", tag}, {co_c, s_c}, e);
        check({"R7 ", tag}, {co_e, s_e}, e);
        check({"R8 ", tag}, {co_f, s_f}, e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        n_run  = 0;
        n_fail = 0;
        done   = 1'b0;
        a = '0; b = '0; ci = 1'b0;
        void'($urandom(32'd20240611));

        // R2: zero operands, both carry-in values.
        apply('0, '0, 1'b0);
        check("R2 zero cin0", {co_d, s_d}, 17'h0_0000);
        apply('0, '0, 1'b1);
        check("R2 zero cin1", {co_d, s_d}, 17'h0_0001);
        check_all("zero");

        // R3: full propagate, carry travels the whole word.
        apply(16'hFFFF, 16'h0000, 1'b1);
        check("R3 ffff+0+1", {co_d, s_d}, 17'h1_0000);
        check_all("prop1");
        apply(16'h5555, 16'hAAAA, 1'b0);
        check("R3 5555+aaaa", {co_d, s_d}, 17'h0_FFFF);
        apply(16'h5555, 16'hAAAA, 1'b1);
        check("R3 5555+aaaa+1", {co_d, s_d}, 17'h1_0000);
        check_all("prop2");
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        check("R1 max", {co_d, s_d}, 17'h1_FFFF);

        // R4: carry generated at each slice top reaches the next slice.
        for (int k = 1; k <= DW; k++) begin
            apply(DW'((17'd1 << k) - 17'd1), 16'h0001, 1'b0);
            check("R4 boundary", {co_d, s_d}, 17'd1 << k);
            check_all("boundary");
        end
        apply(16'h0F00, 16'h0100, 1'b0);
        check("R4 select->lookahead", {co_d, s_d}, 17'h0_1000);
        apply(16'h00F0, 16'h0000, 1'b1);
        check("R4 skip bypass no gen", {co_d, s_d}, 17'h0_00F1);

        // Exhaustive low nibbles with random upper bits.
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int c = 0; c < 2; c++) begin
                    apply({DW'($urandom) & 16'hFFF0} | DW'(x),
                          {DW'($urandom) & 16'hFFF0} | DW'(y), c[0]);
                    check_all("sweep");
                end
            end
        end

        // Random vectors, biased half the time toward long propagate runs.
        for (int i = 0; i < 3000; i++) begin
            logic [DW-1:0] ra;
            ra = DW'($urandom);
            if (i % 2 == 0) apply(ra, ~ra ^ DW'(1 << ($urandom % DW)), 1'($urandom));
            else            apply(ra, DW'($urandom), 1'($urandom));
            check_all("random");
        end

        finish_run();
    end
endmodule